// File: doc/BRIEF.md
# Chip-Select Sequenced Converter Interface Controller

This block is the digital side of a converter's parallel interface. One active-low chip-select pin runs a three-phase sequence. The first falling edge wakes the converter and starts acquisition. The second falling edge freezes the sample and starts conversion. The third falling edge puts the result on the bus.

A read/convert pin is sampled at each falling edge, and its meaning depends on the phase:
- At the first edge, a high level makes the block ignore the edge.
- At the second edge, it selects the power mode applied once the conversion ends: standby keeps the reference on, shutdown turns it off.
- At the third edge, it must be high for the result to be driven.

An active-low end-of-conversion flag reports when the result is ready. The 16-bit result leaves through an 8-bit bus with an output enable, and a byte-select pin picks the high or low byte. The analog path is modelled by a 16-bit sample word that the block captures at the convert edge. Conversion time and reference settling time are parameters counted in clock cycles.

All three control pins are asynchronous. Each passes through a two-flop synchronizer before any edge is detected. After a wake from shutdown, a down-counter tracks reference settling. A convert edge that arrives before that counter expires raises a settle-violation flag. The interface is pin-level and has no valid/ready handshake, so back-pressure does not apply. The host paces every phase through chip select, and the result is held until the read phase ends.

Top module: `cs_seq_adc_ctrl`

## Requirements
- R1: After reset `eoc_n`=1, `bus_oe`=0, `ref_on`=0, `acq_active`=0 and `settle_err`=0. A first chip-select falling edge with `rdconv_pin` low sets `acq_active` and `ref_on`. With `rdconv_pin` high, that edge is ignored and `acq_active` stays 0.
- R2: The second falling edge captures `sample_word`. Later changes of `sample_word` do not alter the result read out.
- R3: `ref_on` stays 1 during conversion. When `eoc_n` falls, `ref_on` is 0 if `rdconv_pin` was 1 at the convert edge (shutdown). It stays 1 if `rdconv_pin` was 0 (standby).
- R4: `eoc_n` stays 1 during conversion. It goes to 0 `CONV_CYCLES` clocks after the convert edge is registered.
- R5: A falling edge with `rdconv_pin`=1 while `eoc_n`=0 sets `bus_oe`. The same edge with `rdconv_pin`=0 is ignored. A rising chip select after the read phase clears `bus_oe` and returns `eoc_n` to 1, rearming the block.
- R6: While the bus is driven, `hbe_pin`=1 presents result bits 15..8 and `hbe_pin`=0 presents bits 7..0. Toggling `hbe_pin` with chip select held low switches the byte.
- R7: `bus_oe` is 0 during acquisition and conversion. Chip-select edges during conversion have no effect.
- R8: Waking while `ref_on`=0 loads a `SETTLE_CYCLES` counter. A convert edge that arrives while this counter is nonzero sets `settle_err`. A convert edge after expiry does not set it, and neither does a wake from standby (no reload).
- R9: `settle_err` clears on the next accepted wake edge.
- R10: The result is straight binary: the bus carries exactly the captured word, including 0x0000 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Active-low chip select, asynchronous |
| rdconv_pin | input | 1 | Read/convert level, asynchronous |
| hbe_pin | input | 1 | High-byte enable, asynchronous |
| sample_word | input | 16 | Stand-in for the analog sample value |
| eoc_n | output | 1 | Active-low end of conversion |
| bus_data | output | 8 | Selected result byte |
| bus_oe | output | 1 | Bus drive enable (0 = high impedance) |
| acq_active | output | 1 | Acquisition phase in progress |
| ref_on | output | 1 | Reference and buffer powered |
| settle_err | output | 1 | Convert edge arrived before reference settled |

## Verification
The hardest situation to reach is a convert edge that lands inside the reference settling window. It needs a wake from the shutdown state and then a second chip-select edge within `SETTLE_CYCLES`. The bench reaches it by starting from reset, where the reference is off, waking, and then converting a few cycles later. The bench also reaches the contrasting case, a wake from standby that reloads nothing, by first finishing a standby conversion and then converting immediately after the next wake. A spurious chip-select edge is also issued during the conversion window to show that it leaves both the flag and the bus untouched.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_DONE,
    ST_READ
  } seq_state_t;

  localparam int unsigned RESULT_W = 16;
  localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/cs_seq_sync.sv
module cs_seq_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/cs_seq_downcnt.sv
module cs_seq_downcnt #(
  parameter int unsigned LOAD_VAL = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);
  localparam int unsigned CW = (LOAD_VAL < 2) ? 1 : $clog2(LOAD_VAL + 1);
  localparam logic [CW-1:0] LV = CW'(LOAD_VAL);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= LV;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end
  assign zero = (cnt == '0);
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import cs_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       rc_s,
  input  logic       conv_zero,
  input  logic       settle_busy,
  output seq_state_t state,
  output logic       conv_load,
  output logic       settle_load,
  output logic       capture,
  output logic       drive,
  output logic       eoc_n,
  output logic       ref_on,
  output logic       settle_err,
  output logic       acq_active
);
  logic mode_sd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      eoc_n      <= 1'b1;
      ref_on     <= 1'b0;
      settle_err <= 1'b0;
      mode_sd    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cs_fall && !rc_s) begin
          state      <= ST_ACQ;
          ref_on     <= 1'b1;
          settle_err <= 1'b0;
        end
        ST_ACQ: if (cs_fall) begin
          state   <= ST_CONV;
          mode_sd <= rc_s;
          if (settle_busy) settle_err <= 1'b1;
        end
        ST_CONV: if (conv_zero) begin
          state <= ST_DONE;
          eoc_n <= 1'b0;
          if (mode_sd) ref_on <= 1'b0;
        end
        ST_DONE: if (cs_fall && rc_s) state <= ST_READ;
        ST_READ: if (cs_rise) begin
          state <= ST_IDLE;
          eoc_n <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    settle_load = (state == ST_IDLE) && cs_fall && !rc_s && !ref_on;
    conv_load   = (state == ST_ACQ) && cs_fall;
    capture     = conv_load;
    drive       = (state == ST_READ);
    acq_active  = (state == ST_ACQ);
  end

  p_ignore_wake_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cs_fall && rc_s) |=> (state == ST_IDLE));
  p_eoc_matches_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DONE) || (state == ST_READ)) == !eoc_n);
  p_ref_on_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV) |-> ref_on);
  p_shutdown_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(eoc_n) && mode_sd) |-> !ref_on);
  p_standby_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(eoc_n) && !mode_sd) |-> ref_on);
  p_settle_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settle_err) |-> (state == ST_CONV));
endmodule

// File: rtl/cs_seq_bytemux.sv
module cs_seq_bytemux
  import cs_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [RESULT_W-1:0] sample_word,
  input  logic                drive,
  input  logic                hbe_s,
  output logic [BYTE_W-1:0]   bus_data,
  output logic                bus_oe
);
  localparam int unsigned NBYTES = RESULT_W / BYTE_W;
  logic [RESULT_W-1:0] result;
  logic [BYTE_W-1:0]   lanes [NBYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result <= '0;
    else if (capture) result <= sample_word;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign lanes[i] = result[i*BYTE_W +: BYTE_W];
  end

  assign bus_data = drive ? lanes[hbe_s ? NBYTES-1 : 0] : '0;
  assign bus_oe   = drive;
endmodule

// File: rtl/cs_seq_adc_ctrl.sv
module cs_seq_adc_ctrl
  import cs_seq_pkg::*;
#(
  parameter int unsigned CONV_CYCLES   = 1175,
  parameter int unsigned SETTLE_CYCLES = 3000000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n_pin,
  input  logic                rdconv_pin,
  input  logic                hbe_pin,
  input  logic [RESULT_W-1:0] sample_word,
  output logic                eoc_n,
  output logic [BYTE_W-1:0]   bus_data,
  output logic                bus_oe,
  output logic                acq_active,
  output logic                ref_on,
  output logic                settle_err
);
  localparam int unsigned CONV_LOAD = (CONV_CYCLES > 0) ? CONV_CYCLES - 1 : 0;

  logic [2:0] pins_s;
  logic cs_s, rc_s, hbe_s, cs_prev, cs_fall, cs_rise;
  logic conv_load, conv_zero, settle_load, settle_zero, capture, drive;
  seq_state_t state;

  cs_seq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({hbe_pin, rdconv_pin, cs_n_pin}), .q(pins_s));
  assign cs_s  = pins_s[0];
  assign rc_s  = pins_s[1];
  assign hbe_s = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_prev <= 1'b1;
    else        cs_prev <= cs_s;
  end
  assign cs_fall = cs_prev && !cs_s;
  assign cs_rise = !cs_prev && cs_s;

  cs_seq_downcnt #(.LOAD_VAL(CONV_LOAD)) u_conv_cnt (
    .clk(clk), .rst_n(rst_n), .load(conv_load), .zero(conv_zero));
  cs_seq_downcnt #(.LOAD_VAL(SETTLE_CYCLES)) u_settle_cnt (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .zero(settle_zero));

  cs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .rc_s(rc_s), .conv_zero(conv_zero), .settle_busy(!settle_zero),
    .state(state), .conv_load(conv_load), .settle_load(settle_load),
    .capture(capture), .drive(drive), .eoc_n(eoc_n), .ref_on(ref_on),
    .settle_err(settle_err), .acq_active(acq_active));

  cs_seq_bytemux u_mux (
    .clk(clk), .rst_n(rst_n), .capture(capture), .sample_word(sample_word),
    .drive(drive), .hbe_s(hbe_s), .bus_data(bus_data), .bus_oe(bus_oe));

  p_bus_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ACQ) || (state == ST_CONV)) |-> !bus_oe);
  p_drive_after_eoc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !eoc_n);
endmodule

// File: tb/tb_cs_seq_adc_ctrl.sv
module tb_cs_seq_adc_ctrl;
  localparam int CONV = 40;
  localparam int SETTLE = 300;
  localparam int GAP = 6;

  logic clk = 0, rst_n = 0;
  logic cs_n_pin = 1, rdconv_pin = 0, hbe_pin = 0;
  logic [15:0] sample_word = '0;
  logic eoc_n, bus_oe, acq_active, ref_on, settle_err;
  logic [7:0] bus_data;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cs_seq_adc_ctrl #(.CONV_CYCLES(CONV), .SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .rdconv_pin(rdconv_pin),
    .hbe_pin(hbe_pin), .sample_word(sample_word), .eoc_n(eoc_n),
    .bus_data(bus_data), .bus_oe(bus_oe), .acq_active(acq_active),
    .ref_on(ref_on), .settle_err(settle_err));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cs_down(input logic rc);
    @(negedge clk) rdconv_pin = rc;
    repeat (2) @(negedge clk);
    cs_n_pin = 0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk) cs_n_pin = 1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset eoc_n", 16'(eoc_n), 16'd1);
    chk("R1 reset bus_oe", 16'(bus_oe), 16'd0);
    chk("R1 reset ref_on", 16'(ref_on), 16'd0);
    chk("R1 reset acq", 16'(acq_active), 16'd0);
    chk("R1 reset settle_err", 16'(settle_err), 16'd0);
  endtask

  task automatic t_ignored_wake();
    cs_down(1'b1);
    chk("R1 wake with rc high ignored", 16'(acq_active), 16'd0);
    chk("R1 ref stays off", 16'(ref_on), 16'd0);
    cs_up();
  endtask

  task automatic t_shutdown_unsettled();
    sample_word = 16'h1234;
    cs_down(1'b0);
    chk("R1 acquisition entered", 16'(acq_active), 16'd1);
    chk("R1 ref powered", 16'(ref_on), 16'd1);
    chk("R7 bus idle in acquisition", 16'(bus_oe), 16'd0);
    cs_up();
    cs_down(1'b1);
    chk("R8 early convert flagged", 16'(settle_err), 16'd1);
    chk("R4 eoc high in conversion", 16'(eoc_n), 16'd1);
    chk("R3 ref on in conversion", 16'(ref_on), 16'd1);
    sample_word = 16'hBEEF;
    cs_up();
    cs_down(1'b1);
    chk("R7 edge in conversion ignored, eoc", 16'(eoc_n), 16'd1);
    chk("R7 bus idle in conversion", 16'(bus_oe), 16'd0);
    cs_up();
    repeat (CONV) @(negedge clk);
    chk("R4 eoc low after conversion", 16'(eoc_n), 16'd0);
    chk("R3 shutdown drops ref", 16'(ref_on), 16'd0);
    hbe_pin = 1;
    cs_down(1'b1);
    chk("R5 read drives bus", 16'(bus_oe), 16'd1);
    chk("R6 high byte / R2 frozen", 16'(bus_data), 16'h12);
    hbe_pin = 0;
    repeat (GAP) @(negedge clk);
    chk("R6 low byte after toggle", 16'(bus_data), 16'h34);
    cs_up();
    chk("R5 cs rise releases bus", 16'(bus_oe), 16'd0);
    chk("R5 cs rise rearms eoc", 16'(eoc_n), 16'd1);
  endtask

  task automatic t_settled_standby();
    sample_word = 16'hFFFF;
    cs_down(1'b0);
    chk("R9 flag cleared on wake", 16'(settle_err), 16'd0);
    cs_up();
    repeat (SETTLE + 20) @(negedge clk);
    cs_down(1'b0);
    chk("R8 settled convert not flagged", 16'(settle_err), 16'd0);
    cs_up();
    repeat (CONV) @(negedge clk);
    chk("R4 eoc low", 16'(eoc_n), 16'd0);
    chk("R3 standby keeps ref", 16'(ref_on), 16'd1);
    cs_down(1'b0);
    chk("R5 read edge with rc low ignored", 16'(bus_oe), 16'd0);
    chk("R5 eoc stays low", 16'(eoc_n), 16'd0);
    cs_up();
    hbe_pin = 1;
    cs_down(1'b1);
    chk("R10 full scale high byte", 16'(bus_data), 16'hFF);
    hbe_pin = 0;
    repeat (GAP) @(negedge clk);
    chk("R10 full scale low byte", 16'(bus_data), 16'hFF);
    cs_up();
  endtask

  task automatic t_standby_quick();
    sample_word = 16'h0000;
    cs_down(1'b0);
    cs_up();
    cs_down(1'b1);
    chk("R8 standby wake needs no settle", 16'(settle_err), 16'd0);
    cs_up();
    repeat (CONV) @(negedge clk);
    chk("R3 shutdown selected drops ref", 16'(ref_on), 16'd0);
    hbe_pin = 1;
    cs_down(1'b1);
    chk("R10 zero code high byte", 16'(bus_data), 16'h00);
    chk("R5 bus driven", 16'(bus_oe), 16'd1);
    cs_up();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ignored_wake();
    t_shutdown_unsettled();
    t_settled_standby();
    t_standby_quick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule